// File: doc/BRIEF.md
# Registered Instruction Decoder and Immediate Generator

This block takes one 32-bit word of a fixed-length, three-format load-store instruction set and turns it into everything the rest of a simple datapath needs. It returns the two source register addresses, the write-back register address, the shift amount, a 32-bit immediate extended according to the opcode, and a set of control strobes: register write, memory read, memory write, byte access, a 2-bit ALU operation, branch-if-equal, branch-if-not-equal, jump, jump-and-link, jump-through-register, set-less-than and load-upper. Any encoding that the block does not know raises an illegal flag, and every write enable stays low.

All outputs are registered. The decode for the word presented on `instr_i` appears on the outputs one clock after the edge that samples it. A synchronous active-high reset clears every output. Register storage, the ALU, the memories and next-PC logic live outside this block.

Top module: `insn_decode`

## Requirements
- R1: While `rst` is high at a rising edge, every output is zero after that edge, whatever `instr_i` holds.
- R2: Outputs reflect the word sampled at the previous rising edge. `rs_addr_o` = bits 25:21, `rt_addr_o` = bits 20:16 and `shamt_o` = bits 10:6 of that word, for every word.
- R3: Opcode 0 (bits 31:26) selects decode by the function field in bits 5:0. Function 32 (add) and 34 (subtract) assert `reg_we_o` with the destination taken from bits 15:11. `alu_op_o` is 0 for add, 1 for subtract, 2 for OR and 3 for signed less-than.
- R4: Opcodes 8 (add-immediate), 35 (load word) and 32 (load byte) write the register named in bits 20:16, with `alu_op_o`=0. Loads also assert `mem_rd_o`, and load byte asserts `byte_o`.
- R5: For add-immediate, set-less-than-immediate, the four loads and stores, the two branches, opcode 0 and illegal words, `imm_o` is bits 15:0 with bit 15 copied into bits 31:16.
- R6: Opcode 13 (OR-immediate) zero-extends bits 15:0, writes the register in bits 20:16 and sets `alu_op_o`=2.
- R7: Opcode 15 (load-upper) gives `imm_o` = {bits 15:0, 16 zeros}. It asserts `lui_o` and writes the register in bits 20:16.
- R8: Opcode 2 (jump) asserts only `jump_o` among the strobes. Opcode 3 (jump-and-link) asserts `jump_o`, `jal_o` and `reg_we_o`, with `wr_addr_o`=31. For both, `imm_o` = {6 zeros, bits 25:0}.
- R9: Opcode 0 with function 8 asserts `jr_o` and leaves `reg_we_o` low. At most one of `beq_o`, `bne_o`, `jump_o`, `jr_o` is high at a time.
- R10: Opcodes 43 (store word) and 40 (store byte) assert `mem_wr_o` without `reg_we_o`, and store byte also asserts `byte_o`. Opcodes 4 and 5 assert `beq_o` and `bne_o` respectively, with `alu_op_o`=1 and no register write.
- R11: Any other opcode, and opcode 0 with any other function value, asserts `illegal_o` with every other strobe low and `alu_op_o`=0. Whenever `reg_we_o` is low, `wr_addr_o` is 0.
- R12: Function 42 under opcode 0 and opcode 10 (set-less-than-immediate) assert `slt_o` with `alu_op_o`=3. The first writes the register in bits 15:11, the second the register in bits 20:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word to decode |
| rs_addr_o | output | 5 | First source register address |
| rt_addr_o | output | 5 | Second source register address |
| wr_addr_o | output | 5 | Write-back register address, 0 when no write |
| shamt_o | output | 5 | Shift amount field |
| imm_o | output | 32 | Extended immediate or jump target |
| reg_we_o | output | 1 | Register write enable |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| byte_o | output | 1 | Byte-sized memory access |
| alu_op_o | output | 2 | 0 add, 1 subtract, 2 OR, 3 signed less-than |
| beq_o | output | 1 | Branch if equal |
| bne_o | output | 1 | Branch if not equal |
| jump_o | output | 1 | Absolute jump |
| jal_o | output | 1 | Jump and link |
| jr_o | output | 1 | Jump through register |
| slt_o | output | 1 | Set-less-than operation |
| lui_o | output | 1 | Load-upper operation |
| illegal_o | output | 1 | Unrecognised encoding |

## Verification
Directed words cover every supported opcode and function value. Immediates 0x8000, 0x7FFF and 0xFFFF separate sign extension, zero extension and the upper-half placement, and a 26-bit target with its top bit set shows that jump targets are not sign-extended. Random words whose opcode and function come from the supported list, with random other fields, show that the register fields come from the right slices and that the destination choice between bits 20:16, bits 15:11 and register 31 follows the format. Fully random words, which mostly fall on unused opcodes or functions, probe the illegal path and its quiet write enables.

// File: rtl/insn_decode_pkg.sv
package insn_decode_pkg;

  localparam int unsigned XLEN   = 32;
  localparam int unsigned RAW    = 5;
  localparam int unsigned OPW    = 6;
  localparam int unsigned IMMW   = 16;
  localparam int unsigned TGTW   = 26;

  localparam logic [OPW-1:0] OP_RTYPE = 6'd0;
  localparam logic [OPW-1:0] OP_J     = 6'd2;
  localparam logic [OPW-1:0] OP_JAL   = 6'd3;
  localparam logic [OPW-1:0] OP_BEQ   = 6'd4;
  localparam logic [OPW-1:0] OP_BNE   = 6'd5;
  localparam logic [OPW-1:0] OP_ADDI  = 6'd8;
  localparam logic [OPW-1:0] OP_SLTI  = 6'd10;
  localparam logic [OPW-1:0] OP_ORI   = 6'd13;
  localparam logic [OPW-1:0] OP_LUI   = 6'd15;
  localparam logic [OPW-1:0] OP_LB    = 6'd32;
  localparam logic [OPW-1:0] OP_LW    = 6'd35;
  localparam logic [OPW-1:0] OP_SB    = 6'd40;
  localparam logic [OPW-1:0] OP_SW    = 6'd43;

  localparam logic [OPW-1:0] FN_JR  = 6'd8;
  localparam logic [OPW-1:0] FN_ADD = 6'd32;
  localparam logic [OPW-1:0] FN_SUB = 6'd34;
  localparam logic [OPW-1:0] FN_SLT = 6'd42;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2,
    ALU_SLT = 2'd3
  } alu_op_e;

  typedef enum logic [1:0] {
    IMM_SX  = 2'd0,
    IMM_ZX  = 2'd1,
    IMM_HI  = 2'd2,
    IMM_TGT = 2'd3
  } imm_kind_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_RD   = 2'd1,
    DST_RT   = 2'd2,
    DST_LINK = 2'd3
  } dst_kind_e;

  typedef struct packed {
    logic      reg_we;
    logic      mem_rd;
    logic      mem_wr;
    logic      byte_acc;
    alu_op_e   alu_op;
    logic      beq;
    logic      bne;
    logic      jump;
    logic      jal;
    logic      jr;
    logic      slt;
    logic      lui;
    logic      illegal;
    imm_kind_e imm_kind;
    dst_kind_e dst_kind;
  } ctrl_t;

  typedef struct packed {
    logic [RAW-1:0]  rs;
    logic [RAW-1:0]  rt;
    logic [RAW-1:0]  wr;
    logic [RAW-1:0]  shamt;
    logic [XLEN-1:0] imm;
    ctrl_t           ctl;
  } dec_out_t;

endpackage

// File: rtl/insn_ctrl_decode.sv
module insn_ctrl_decode
  import insn_decode_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  input  logic [OPW-1:0] fn_i,
  output ctrl_t          ctl_o
);

  always_comb begin
    ctl_o = '0;
    unique case (op_i)
      OP_RTYPE: begin
        unique case (fn_i)
          FN_ADD: begin
            ctl_o.reg_we   = 1'b1;
            ctl_o.dst_kind = DST_RD;
            ctl_o.alu_op   = ALU_ADD;
          end
          FN_SUB: begin
            ctl_o.reg_we   = 1'b1;
            ctl_o.dst_kind = DST_RD;
            ctl_o.alu_op   = ALU_SUB;
          end
          FN_SLT: begin
            ctl_o.reg_we   = 1'b1;
            ctl_o.dst_kind = DST_RD;
            ctl_o.alu_op   = ALU_SLT;
            ctl_o.slt      = 1'b1;
          end
          FN_JR:   ctl_o.jr      = 1'b1;
          default: ctl_o.illegal = 1'b1;
        endcase
      end
      OP_ADDI: begin
        ctl_o.reg_we   = 1'b1;
        ctl_o.dst_kind = DST_RT;
      end
      OP_SLTI: begin
        ctl_o.reg_we   = 1'b1;
        ctl_o.dst_kind = DST_RT;
        ctl_o.alu_op   = ALU_SLT;
        ctl_o.slt      = 1'b1;
      end
      OP_ORI: begin
        ctl_o.reg_we   = 1'b1;
        ctl_o.dst_kind = DST_RT;
        ctl_o.alu_op   = ALU_OR;
        ctl_o.imm_kind = IMM_ZX;
      end
      OP_LUI: begin
        ctl_o.reg_we   = 1'b1;
        ctl_o.dst_kind = DST_RT;
        ctl_o.lui      = 1'b1;
        ctl_o.imm_kind = IMM_HI;
      end
      OP_LW, OP_LB: begin
        ctl_o.reg_we   = 1'b1;
        ctl_o.dst_kind = DST_RT;
        ctl_o.mem_rd   = 1'b1;
        ctl_o.byte_acc = (op_i == OP_LB);
      end
      OP_SW, OP_SB: begin
        ctl_o.mem_wr   = 1'b1;
        ctl_o.byte_acc = (op_i == OP_SB);
      end
      OP_BEQ: begin
        ctl_o.beq    = 1'b1;
        ctl_o.alu_op = ALU_SUB;
      end
      OP_BNE: begin
        ctl_o.bne    = 1'b1;
        ctl_o.alu_op = ALU_SUB;
      end
      OP_J: begin
        ctl_o.jump     = 1'b1;
        ctl_o.imm_kind = IMM_TGT;
      end
      OP_JAL: begin
        ctl_o.jump     = 1'b1;
        ctl_o.jal      = 1'b1;
        ctl_o.reg_we   = 1'b1;
        ctl_o.dst_kind = DST_LINK;
        ctl_o.imm_kind = IMM_TGT;
      end
      default: ctl_o.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/insn_imm_gen.sv
module insn_imm_gen
  import insn_decode_pkg::*;
(
  input  logic [XLEN-1:0] instr_i,
  input  imm_kind_e       kind_i,
  output logic [XLEN-1:0] imm_o
);

  localparam int unsigned HI_PAD  = XLEN - IMMW;
  localparam int unsigned TGT_PAD = XLEN - TGTW;

  logic [IMMW-1:0] raw16;
  logic [TGTW-1:0] raw26;

  assign raw16 = instr_i[IMMW-1:0];
  assign raw26 = instr_i[TGTW-1:0];

  always_comb begin
    unique case (kind_i)
      IMM_ZX:  imm_o = {{HI_PAD{1'b0}}, raw16};
      IMM_HI:  imm_o = {raw16, {HI_PAD{1'b0}}};
      IMM_TGT: imm_o = {{TGT_PAD{1'b0}}, raw26};
      default: imm_o = {{HI_PAD{raw16[IMMW-1]}}, raw16};
    endcase
  end

endmodule

// File: rtl/insn_dst_sel.sv
module insn_dst_sel
  import insn_decode_pkg::*;
#(
  parameter logic [RAW-1:0] LINK_REG = 5'd31
) (
  input  logic [RAW-1:0] rt_i,
  input  logic [RAW-1:0] rd_i,
  input  dst_kind_e      kind_i,
  output logic [RAW-1:0] wr_o
);

  always_comb begin
    unique case (kind_i)
      DST_RD:   wr_o = rd_i;
      DST_RT:   wr_o = rt_i;
      DST_LINK: wr_o = LINK_REG;
      default:  wr_o = '0;
    endcase
  end

endmodule

// File: rtl/insn_decode.sv
module insn_decode
  import insn_decode_pkg::*;
#(
  parameter logic [RAW-1:0] LINK_REG = 5'd31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [XLEN-1:0]  instr_i,
  output logic [RAW-1:0]   rs_addr_o,
  output logic [RAW-1:0]   rt_addr_o,
  output logic [RAW-1:0]   wr_addr_o,
  output logic [RAW-1:0]   shamt_o,
  output logic [XLEN-1:0]  imm_o,
  output logic             reg_we_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic             byte_o,
  output logic [1:0]       alu_op_o,
  output logic             beq_o,
  output logic             bne_o,
  output logic             jump_o,
  output logic             jal_o,
  output logic             jr_o,
  output logic             slt_o,
  output logic             lui_o,
  output logic             illegal_o
);

  localparam int unsigned OP_LSB = XLEN - OPW;
  localparam int unsigned RS_LSB = OP_LSB - RAW;
  localparam int unsigned RT_LSB = RS_LSB - RAW;
  localparam int unsigned RD_LSB = RT_LSB - RAW;
  localparam int unsigned SH_LSB = RD_LSB - RAW;

  ctrl_t           ctl_d;
  logic [XLEN-1:0] imm_d;
  logic [RAW-1:0]  wr_d;
  dec_out_t        dec_d;
  dec_out_t        dec_q;

  insn_ctrl_decode u_ctrl (
    .op_i  (instr_i[XLEN-1:OP_LSB]),
    .fn_i  (instr_i[OPW-1:0]),
    .ctl_o (ctl_d)
  );

  insn_imm_gen u_imm (
    .instr_i (instr_i),
    .kind_i  (ctl_d.imm_kind),
    .imm_o   (imm_d)
  );

  insn_dst_sel #(.LINK_REG(LINK_REG)) u_dst (
    .rt_i   (instr_i[RS_LSB-1:RT_LSB]),
    .rd_i   (instr_i[RT_LSB-1:RD_LSB]),
    .kind_i (ctl_d.dst_kind),
    .wr_o   (wr_d)
  );

  always_comb begin
    dec_d.rs    = instr_i[OP_LSB-1:RS_LSB];
    dec_d.rt    = instr_i[RS_LSB-1:RT_LSB];
    dec_d.wr    = wr_d;
    dec_d.shamt = instr_i[RD_LSB-1:SH_LSB];
    dec_d.imm   = imm_d;
    dec_d.ctl   = ctl_d;
  end

  always_ff @(posedge clk) begin
    if (rst) dec_q <= '0;
    else     dec_q <= dec_d;
  end

  assign rs_addr_o = dec_q.rs;
  assign rt_addr_o = dec_q.rt;
  assign wr_addr_o = dec_q.wr;
  assign shamt_o   = dec_q.shamt;
  assign imm_o     = dec_q.imm;
  assign reg_we_o  = dec_q.ctl.reg_we;
  assign mem_rd_o  = dec_q.ctl.mem_rd;
  assign mem_wr_o  = dec_q.ctl.mem_wr;
  assign byte_o    = dec_q.ctl.byte_acc;
  assign alu_op_o  = dec_q.ctl.alu_op;
  assign beq_o     = dec_q.ctl.beq;
  assign bne_o     = dec_q.ctl.bne;
  assign jump_o    = dec_q.ctl.jump;
  assign jal_o     = dec_q.ctl.jal;
  assign jr_o      = dec_q.ctl.jr;
  assign slt_o     = dec_q.ctl.slt;
  assign lui_o     = dec_q.ctl.lui;
  assign illegal_o = dec_q.ctl.illegal;

  p_store_nowe_r10: assert property (@(posedge clk) disable iff (rst)
    mem_wr_o |-> (!reg_we_o && !mem_rd_o));

  p_illegal_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> !(reg_we_o || mem_wr_o || mem_rd_o || jump_o || jr_o));

  p_wr_zero_r11: assert property (@(posedge clk) disable iff (rst)
    !reg_we_o |-> (wr_addr_o == '0));

  p_flow_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({beq_o, bne_o, jump_o, jr_o}));

  p_jal_link_r8: assert property (@(posedge clk) disable iff (rst)
    jal_o |-> (reg_we_o && jump_o && wr_addr_o == LINK_REG));

  p_lui_place_r7: assert property (@(posedge clk) disable iff (rst)
    lui_o |-> (imm_o[IMMW-1:0] == '0 && imm_o[XLEN-1:IMMW] == $past(instr_i[IMMW-1:0])));

  p_slt_alu_r12: assert property (@(posedge clk) disable iff (rst)
    slt_o |-> (alu_op_o == ALU_SLT && reg_we_o));

endmodule

// File: tb/insn_decode_tb_top.sv
module insn_decode_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = 32'h0;

  logic [4:0]  rs_addr, rt_addr, wr_addr, shamt;
  logic [31:0] imm;
  logic        reg_we, mem_rd, mem_wr, byte_acc;
  logic [1:0]  alu_op;
  logic        beq, bne, jump, jal, jr, slt, lui, illegal;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  insn_decode dut_i (
    .clk(clk), .rst(rst), .instr_i(instr),
    .rs_addr_o(rs_addr), .rt_addr_o(rt_addr), .wr_addr_o(wr_addr),
    .shamt_o(shamt), .imm_o(imm), .reg_we_o(reg_we), .mem_rd_o(mem_rd),
    .mem_wr_o(mem_wr), .byte_o(byte_acc), .alu_op_o(alu_op),
    .beq_o(beq), .bne_o(bne), .jump_o(jump), .jal_o(jal), .jr_o(jr),
    .slt_o(slt), .lui_o(lui), .illegal_o(illegal)
  );

  // Packed view: rs, rt, wr, shamt, imm, we, rd, wr, byte, alu, beq, bne, j, jal, jr, slt, lui, ill
  function automatic logic [65:0] actual();
    return {rs_addr, rt_addr, wr_addr, shamt, imm, reg_we, mem_rd, mem_wr,
            byte_acc, alu_op, beq, bne, jump, jal, jr, slt, lui, illegal};
  endfunction

  function automatic logic [65:0] model(logic [31:0] w);
    logic [5:0]  op = w[31:26];
    logic [5:0]  fn = w[5:0];
    logic [31:0] im = {{16{w[15]}}, w[15:0]};
    logic [4:0]  dst = 5'd0;
    logic we = 0, mr = 0, mw = 0, by = 0, fb = 0, fn_bne = 0, fj = 0, fjl = 0;
    logic fjr = 0, fs = 0, fl = 0, il = 0;
    logic [1:0] al = 2'd0;
    if (op == 6'd0) begin
      if (fn == 6'd32) begin we = 1; dst = w[15:11]; end
      else if (fn == 6'd34) begin we = 1; dst = w[15:11]; al = 2'd1; end
      else if (fn == 6'd42) begin we = 1; dst = w[15:11]; al = 2'd3; fs = 1; end
      else if (fn == 6'd8) fjr = 1;
      else il = 1;
    end else if (op == 6'd8) begin we = 1; dst = w[20:16]; end
    else if (op == 6'd10) begin we = 1; dst = w[20:16]; al = 2'd3; fs = 1; end
    else if (op == 6'd13) begin we = 1; dst = w[20:16]; al = 2'd2; im = {16'h0, w[15:0]}; end
    else if (op == 6'd15) begin we = 1; dst = w[20:16]; fl = 1; im = {w[15:0], 16'h0}; end
    else if (op == 6'd35 || op == 6'd32) begin we = 1; dst = w[20:16]; mr = 1; by = (op == 6'd32); end
    else if (op == 6'd43 || op == 6'd40) begin mw = 1; by = (op == 6'd40); end
    else if (op == 6'd4) begin fb = 1; al = 2'd1; end
    else if (op == 6'd5) begin fn_bne = 1; al = 2'd1; end
    else if (op == 6'd2) begin fj = 1; im = {6'h0, w[25:0]}; end
    else if (op == 6'd3) begin fj = 1; fjl = 1; we = 1; dst = 5'd31; im = {6'h0, w[25:0]}; end
    else il = 1;
    return {w[25:21], w[20:16], dst, w[10:6], im, we, mr, mw, by, al,
            fb, fn_bne, fj, fjl, fjr, fs, fl, il};
  endfunction

  function automatic string tag_of(logic [31:0] w);
    case (w[31:26])
      6'd0: begin
        if (w[5:0] == 6'd32 || w[5:0] == 6'd34) return "R3";
        if (w[5:0] == 6'd42) return "R12";
        if (w[5:0] == 6'd8) return "R9";
        return "R11";
      end
      6'd8, 6'd35, 6'd32: return "R4";
      6'd10: return "R12";
      6'd13: return "R6";
      6'd15: return "R7";
      6'd2, 6'd3: return "R8";
      6'd43, 6'd40, 6'd4, 6'd5: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic compare(string tag, logic [65:0] exp, logic [31:0] w);
    logic [65:0] act = actual();
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s instr=%h actual=%h expected=%h", tag, w, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] w, string tag);
    @(negedge clk);
    instr = w;
    @(negedge clk);
    compare(tag, model(w), w);
  endtask

  function automatic logic [31:0] itype(logic [5:0] op, logic [15:0] k);
    return {op, 5'd7, 5'd19, k};
  endfunction

  localparam logic [5:0] LEGAL_OP [16] = '{6'd0, 6'd0, 6'd0, 6'd0, 6'd8, 6'd10,
    6'd13, 6'd15, 6'd35, 6'd43, 6'd32, 6'd40, 6'd4, 6'd5, 6'd2, 6'd3};
  localparam logic [5:0] LEGAL_FN [4] = '{6'd32, 6'd34, 6'd42, 6'd8};

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset holds all outputs at zero
    instr = {6'd3, 26'h3FFFFFF};
    repeat (3) @(negedge clk);
    compare("R1", 66'h0, instr);
    @(negedge clk);
    rst = 1'b0;
    // R2: field slices on an add with all fields distinct
    apply({6'd0, 5'd17, 5'd9, 5'd22, 5'd13, 6'd32}, "R2");
    apply({6'd0, 5'd1, 5'd2, 5'd3, 5'd31, 6'd34}, "R3");
    apply({6'd0, 5'd4, 5'd5, 5'd6, 5'd0, 6'd42}, "R12");
    apply({6'd0, 5'd31, 5'd0, 5'd0, 5'd0, 6'd8}, "R9");
    // R5: sign extension of negative and positive immediates
    apply(itype(6'd8, 16'h8000), "R5");
    apply(itype(6'd8, 16'h7FFF), "R5");
    apply(itype(6'd10, 16'hFFFF), "R12");
    apply(itype(6'd35, 16'hFFFC), "R4");
    apply(itype(6'd32, 16'h8001), "R4");
    apply(itype(6'd43, 16'h8008), "R10");
    apply(itype(6'd40, 16'h0006), "R10");
    apply(itype(6'd4, 16'hFFFF), "R10");
    apply(itype(6'd5, 16'h8000), "R10");
    // R6: zero extension for OR-immediate
    apply(itype(6'd13, 16'hFFFF), "R6");
    apply(itype(6'd13, 16'h8000), "R6");
    // R7: upper placement
    apply(itype(6'd15, 16'h8001), "R7");
    apply(itype(6'd15, 16'hAAAA), "R7");
    // R8: jump targets are not sign-extended
    apply({6'd2, 26'h2000001}, "R8");
    apply({6'd3, 26'h3FFFFFF}, "R8");
    // R11: unused opcode and unused function values
    apply({6'd1, 26'h3FFFFFF}, "R11");
    apply({6'd63, 26'h0}, "R11");
    apply({6'd0, 5'd3, 5'd4, 5'd5, 5'd0, 6'd9}, "R11");
    apply({6'd0, 5'd3, 5'd4, 5'd5, 5'd0, 6'd33}, "R11");
    // Random words with supported opcode and function
    for (int i = 0; i < 300; i++) begin
      logic [31:0] w = $urandom();
      int k = $urandom_range(0, 15);
      w[31:26] = LEGAL_OP[k];
      if (LEGAL_OP[k] == 6'd0) w[5:0] = LEGAL_FN[$urandom_range(0, 3)];
      apply(w, tag_of(w));
    end
    // Fully random words, mostly unused encodings
    for (int i = 0; i < 200; i++) begin
      logic [31:0] w = $urandom();
      apply(w, tag_of(w));
    end
    // R1: reset in mid-stream clears a live decode
    @(negedge clk);
    instr = {6'd3, 26'h155};
    rst = 1'b1;
    @(negedge clk);
    compare("R1", 66'h0, instr);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule